// File: doc/BRIEF.md
# Selectable Arithmetic-Logic Slice

This block is a combinational N-bit arithmetic-logic unit. It is built from a chain of identical bit cells. Each cell holds one full adder, and the carry ripples from the least significant bit upward. A 3-bit function select and a carry input together pick one of eight arithmetic results or one of four bitwise results. The outputs are the N-bit result and the carry out of the top cell.

In arithmetic mode, the top select bit is 0. The low two select bits choose the adder's second operand: zero, B, the complement of B, or all ones. The carry input then adds one. This gives pass, increment, add, add-plus-one, subtract, subtract-with-borrow, decrement, and a second pass. In logic mode, the top select bit is 1. The low two bits pick OR, XOR, AND or NOT A. The carry input has no effect in logic mode, and the carry out is held low.

Top module: `alu_slice`

## Requirements
- R1: With func_sel=3'b000, result is opa when carry_in=0 and opa+1 (mod 2^WIDTH) when carry_in=1.
- R2: With func_sel=3'b001, result is opa+opb when carry_in=0 and opa+opb+1 when carry_in=1 (mod 2^WIDTH).
- R3: With func_sel=3'b010, result is opa-opb-1 when carry_in=0 and opa-opb when carry_in=1 (mod 2^WIDTH).
- R4: With func_sel=3'b011, result is opa-1 when carry_in=0 and opa when carry_in=1 (mod 2^WIDTH).
- R5: In arithmetic mode (func_sel[2]=0), carry_out is bit WIDTH of the unsigned sum opa + X + carry_in. X is the steered operand: 0 for low select bits 00, opb for 01, ~opb for 10, and all ones for 11.
- R6: In logic mode (func_sel[2]=1), the low select bits pick the result: 00 gives opa|opb, 01 gives opa^opb, 10 gives opa&opb, and 11 gives ~opa.
- R7: In logic mode, carry_in has no effect on result.
- R8: In logic mode, carry_out is 0.
- R9: The width is the parameter WIDTH (default 8), and every rule above holds for other widths.
- R10: Each bit cell produces the two-bit sum of its operand bit, its steered bit and its incoming carry. Bit 0 takes carry_in, and each higher cell takes the carry of the cell below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| func_sel | input | 3 | Bit 2 chooses logic mode; bits 1:0 pick the operand steering or the logic function |
| carry_in | input | 1 | Carry into bit 0 (arithmetic mode only) |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Carry out of the top cell; 0 in logic mode |

## Verification
The bench builds two copies of the block. The first uses the default WIDTH of 8. It is driven with random operands and with edge operands such as zero, all ones and the sign-boundary values, under all sixteen combinations of select and carry input. The second copy uses WIDTH=4, which makes an exhaustive sweep of every operand pair, select value and carry input affordable. That sweep reaches every full-length carry ripple, every borrow case and every wrap-around.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  // steering picks for arithmetic mode (func_sel[1:0])
  localparam logic [1:0] STEER_ZERO = 2'b00;
  localparam logic [1:0] STEER_B    = 2'b01;
  localparam logic [1:0] STEER_INVB = 2'b10;
  localparam logic [1:0] STEER_ONES = 2'b11;

  // function picks for logic mode (func_sel[1:0])
  localparam logic [1:0] LFN_OR   = 2'b00;
  localparam logic [1:0] LFN_XOR  = 2'b01;
  localparam logic [1:0] LFN_AND  = 2'b10;
  localparam logic [1:0] LFN_NOTA = 2'b11;

  typedef struct packed {
    logic       logic_mode;
    logic [1:0] pick;
  } func_sel_t;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/alu_operand_steer.sv
module alu_operand_steer
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       pick,
  output logic [WIDTH-1:0] addend
);
  always_comb begin
    case (pick)
      STEER_ZERO: addend = '0;
      STEER_B:    addend = opb;
      STEER_INVB: addend = ~opb;
      default:    addend = '1;
    endcase
  end

  // R5
  always_comb begin
    if (pick == STEER_INVB) begin
      steer_invb_chk: assert (((addend & opb) == '0) && ((addend | opb) == '1))
        else $error("steered operand is not the complement of B");
    end
    if (pick == STEER_ONES) begin
      steer_ones_chk: assert ($countones(addend) == WIDTH)
        else $error("steered operand is not all ones");
    end
  end
endmodule

// File: rtl/alu_fa_cell.sv
module alu_fa_cell
  import alu_slice_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic s,
  output logic cout
);
  assign s    = fa_sum(a, b, cin);
  assign cout = fa_carry(a, b, cin);

  // R10
  always_comb begin
    fa_cell_sum_chk: assert ((2'(a) + 2'(b) + 2'(cin)) == {cout, s})
      else $error("cell sum does not equal count of its inputs");
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       pick,
  output logic [WIDTH-1:0] lres
);
  always_comb begin
    case (pick)
      LFN_OR:  lres = opa | opb;
      LFN_XOR: lres = opa ^ opb;
      LFN_AND: lres = opa & opb;
      default: lres = ~opa;
    endcase
  end

  // R6
  always_comb begin
    if (pick == LFN_NOTA) begin
      logic_nota_chk: assert (((lres & opa) == '0) && ((lres | opa) == '1))
        else $error("NOT A result overlaps A");
    end
    if (pick == LFN_XOR) begin
      logic_xor_chk: assert ((lres ^ opa) == opb)
        else $error("XOR result does not recover B");
    end
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       func_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int SUM_W = WIDTH + 1;

  func_sel_t               sel;
  logic [WIDTH-1:0]        addend;
  logic [WIDTH-1:0]        arith_sum;
  logic [WIDTH:0]          chain;
  logic [WIDTH-1:0]        logic_res;
  logic                    top_carry;

  assign sel      = func_sel_t'(func_sel);
  assign chain[0] = carry_in;

  alu_operand_steer #(.WIDTH(WIDTH)) steer_i (
    .opb    (opb),
    .pick   (sel.pick),
    .addend (addend)
  );

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
    alu_fa_cell cell_i (
      .a    (opa[gi]),
      .b    (addend[gi]),
      .cin  (chain[gi]),
      .s    (arith_sum[gi]),
      .cout (chain[gi+1])
    );
  end

  assign top_carry = chain[WIDTH];

  alu_logic_unit #(.WIDTH(WIDTH)) lu_i (
    .opa  (opa),
    .opb  (opb),
    .pick (sel.pick),
    .lres (logic_res)
  );

  always_comb begin
    if (sel.logic_mode) begin
      result    = logic_res;
      carry_out = 1'b0;
    end else begin
      result    = arith_sum;
      carry_out = top_carry;
    end
  end

  always_comb begin
    if (!sel.logic_mode) begin
      // R5
      arith_sum_chk: assert ({carry_out, result} ==
                             (SUM_W'(opa) + SUM_W'(addend) + SUM_W'(carry_in)))
        else $error("ripple chain disagrees with wide sum");
    end else begin
      // R8
      logic_cout_chk: assert (carry_out == 1'b0)
        else $error("carry out raised in logic mode");
    end
  end
endmodule

// File: tb/alu_slice_tb_top.sv
module alu_slice_tb_top;
  localparam int W8 = 8;
  localparam int W4 = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [W8-1:0] a8, b8, r8;
  logic [2:0]    s8;
  logic          c8, co8;
  logic [W4-1:0] a4, b4, r4;
  logic [2:0]    s4;
  logic          c4, co4;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  alu_slice #(.WIDTH(W8)) dut_i (
    .opa(a8), .opb(b8), .func_sel(s8), .carry_in(c8),
    .result(r8), .carry_out(co8));

  alu_slice #(.WIDTH(W4)) dut_w4 (
    .opa(a4), .opb(b4), .func_sel(s4), .carry_in(c4),
    .result(r4), .carry_out(co4));

  // behavioural reference, written from the requirements
  function automatic void ref_model(input int w, input longint a, input longint b,
                                    input int sel, input int cin,
                                    output longint r, output int co);
    longint m = longint'(1) << w;
    longint t;
    if (sel >= 4) begin
      case (sel % 4)
        0: r = a | b;
        1: r = a ^ b;
        2: r = a & b;
        default: r = (~a) & (m - 1);
      endcase
      co = 0;
    end else begin
      case (sel)
        0: t = a + cin;
        1: t = a + b + cin;
        2: t = a - b - 1 + cin + m;
        default: t = a - 1 + cin + m;
      endcase
      r  = t % m;
      co = (t >= m) ? 1 : 0;
    end
  endfunction

  function automatic string res_tag(input int sel, input int cin);
    if (sel == 0) return "R1";
    if (sel == 1) return "R2";
    if (sel == 2) return "R3";
    if (sel == 3) return "R4";
    if (cin == 1) return "R7";
    return "R6";
  endfunction

  function automatic string co_tag(input int sel);
    return (sel >= 4) ? "R8" : "R5";
  endfunction

  task automatic check(input string tag, input int w, input int sel, input int cin,
                       input longint a, input longint b,
                       input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s w=%0d sel=%0d cin=%0d a=%0h b=%0h %s actual=%0h expected=%0h",
               tag, w, sel, cin, a, b, what, act, exp);
    end
  endtask

  task automatic run8(input logic [W8-1:0] a, input logic [W8-1:0] b,
                      input int sel, input int cin);
    longint er; int ec;
    @(posedge clk);
    a8 = a; b8 = b; s8 = 3'(sel); c8 = 1'(cin);
    @(negedge clk);
    ref_model(W8, longint'(a), longint'(b), sel, cin, er, ec);
    check(res_tag(sel, cin), W8, sel, cin, a, b, longint'(r8), er, "result");
    check(co_tag(sel), W8, sel, cin, a, b, longint'(co8), longint'(ec), "carry_out");
  endtask

  task automatic run4(input int a, input int b, input int sel, input int cin);
    longint er; int ec;
    @(posedge clk);
    a4 = 4'(a); b4 = 4'(b); s4 = 3'(sel); c4 = 1'(cin);
    @(negedge clk);
    ref_model(W4, longint'(a), longint'(b), sel, cin, er, ec);
    // R9: narrow instance must obey the same rules
    check({"R9/", res_tag(sel, cin)}, W4, sel, cin, a, b, longint'(r4), er, "result");
    check({"R9/", co_tag(sel)}, W4, sel, cin, a, b, longint'(co4), longint'(ec), "carry_out");
  endtask

  initial begin
    a8 = '0; b8 = '0; s8 = '0; c8 = 1'b0;
    a4 = '0; b4 = '0; s4 = '0; c4 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // quiescent state: all-zero inputs pass zero through (R1)
    check("R1", W8, 0, 0, 0, 0, longint'(r8), 0, "result");
    check("R5", W8, 0, 0, 0, 0, longint'(co8), 0, "carry_out");

    // R10: full ripple from bit 0 to the top cell
    run8(8'hFF, 8'h01, 1, 0);
    run8(8'hFF, 8'h00, 0, 1);
    run8(8'h00, 8'h00, 3, 0);
    run8(8'h7F, 8'h01, 1, 0);
    run8(8'h80, 8'h01, 2, 1);
    run8(8'h00, 8'hFF, 2, 0);

    // edge operands under every control combination
    for (int sel = 0; sel < 8; sel++)
      for (int cin = 0; cin < 2; cin++) begin
        run8(8'h00, 8'h00, sel, cin);
        run8(8'hFF, 8'hFF, sel, cin);
        run8(8'h80, 8'h7F, sel, cin);
        run8(8'h7F, 8'h80, sel, cin);
        run8(8'hA5, 8'h5A, sel, cin);
      end

    // random operands, every control combination
    for (int k = 0; k < 200; k++)
      for (int sel = 0; sel < 8; sel++)
        for (int cin = 0; cin < 2; cin++)
          run8(8'($urandom), 8'($urandom), sel, cin);

    // R7: same logic-mode operands with both carry inputs
    for (int k = 0; k < 50; k++) begin
      logic [W8-1:0] ra, rb;
      ra = 8'($urandom); rb = 8'($urandom);
      for (int sel = 4; sel < 8; sel++) begin
        logic [W8-1:0] r_c0;
        run8(ra, rb, sel, 0);
        r_c0 = r8;
        run8(ra, rb, sel, 1);
        check("R7", W8, sel, 1, ra, rb, longint'(r8), longint'(r_c0), "result vs carry_in=0");
      end
    end

    // R9: exhaustive sweep of the 4-bit instance
    for (int sel = 0; sel < 8; sel++)
      for (int cin = 0; cin < 2; cin++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            run4(a, b, sel, cin);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule